// File: doc/BRIEF.md
# Nonvolatile Memory Access Control Register

This block is the byte-wide control and status register that a processor uses to drive accesses to an on-chip nonvolatile store. The store may be data EEPROM, program flash or configuration space. Software writes the register to pick a target, arm writes, ask for a row erase, and start a read or a self-timed write or erase. The memory side of the block gives a one-cycle read strobe, a one-cycle write or erase start strobe and the two target selects. It takes a completion input from the programming engine.

A built-in cycle counter, sized by a parameter, stands in for the self-timed programming time. This lets the block be tested on its own. The memory-side completion input can also end an operation. There are two resets. Power-on reset is asynchronous and clears everything. Warm reset is sampled on the clock and aborts a running operation. When it does, it leaves an error flag set and keeps the target and erase selections, so the failed operation can be traced.

Top module: `nvm_ctl_reg`

## Requirements
- R1: The register reads as {bit7 prog-target, bit6 config-space, bit5 constant 0, bit4 row-erase, bit3 error, bit2 write-enable, bit1 write-start, bit0 read-start}. When idle, a software write to bits 7, 6, 4, 3 and 2 reads back as written.
- R2: After power-on reset every bit reads 0 and no strobe is active.
- R3: Writing 1 to bit0 while idle pulses mem_rd_stb and bit0 high for exactly one cycle. Both fall again without software action.
- R4: A read request is dropped when the same write sets bit7 to 1. In that case bit0 and mem_rd_stb stay 0.
- R5: Software can set write-start but cannot clear it. Once set, it stays at 1 for PROG_CYCLES cycles and is then cleared by the block.
- R6: A write or erase starts only if write-enable was already 1 before the write that sets bit1. Otherwise bit1 stays 0 and no strobe is given.
- R7: If row-erase is 1 at start, mem_erase_stb pulses instead of mem_wr_stb. Row-erase reads 0 once the operation completes.
- R8: A warm reset while write-start is 1 sets the error bit. It clears write-enable, write-start and read-start. The target, config and row-erase bits keep their values.
- R9: An operation that completes normally leaves the error bit at 0.
- R10: While write-start is 1, a software write changes only write-enable.
- R11: A warm reset while idle leaves the error bit unchanged. It clears write-enable, and the target, config and row-erase bits keep their values.
- R12: Exactly one start strobe is given, in the first cycle that write-start reads 1. mem_sel_prog and mem_sel_cfg follow bits 7 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| wrst_n | input | 1 | Warm reset, synchronous, active low |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| mem_rd_stb | output | 1 | One-cycle read strobe |
| mem_wr_stb | output | 1 | One-cycle write start strobe |
| mem_erase_stb | output | 1 | One-cycle row erase start strobe |
| mem_sel_prog | output | 1 | Target is program memory |
| mem_sel_cfg | output | 1 | Target is configuration space |
| mem_done | input | 1 | Completion from the programming engine |

## Verification
Several properties are checked on every cycle:
- A read strobe never appears with the program target selected.
- Write-start only rises after write-enable was already set.
- Write-start never drops before completion unless a warm reset arrives.
- Start strobes only appear while write-start reads 1.
- A busy write leaves the target bits alone.
- A warm reset during a write leaves the error bit set with the selections kept.

Other behaviours can only be shown by the bench's scenarios. These are the exact length of the busy window, row-erase clearing at completion, the error bit clearing after a clean operation, and readback of the full layout. The bench covers them with directed sequences and with a seeded random mix of writes and warm resets, compared against a reference model.

// File: rtl/nvm_ctl_reg.sv
module nvm_ctl_reg #(
  parameter int PROG_CYCLES = 16,
  parameter bit INT_TIMER   = 1'b1
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       wrst_n,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       mem_rd_stb,
  output logic       mem_wr_stb,
  output logic       mem_erase_stb,
  output logic       mem_sel_prog,
  output logic       mem_sel_cfg,
  input  logic       mem_done
);
  localparam int CW = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;

  logic pgm_q, cfg_q, er_q, err_q, wren_q, wr_q, rd_q, start_q;
  logic [CW-1:0] cnt_q;
  logic timer_hit, done_w;

  generate
    if (INT_TIMER) begin : g_int_timer
      assign timer_hit = (cnt_q == CW'(PROG_CYCLES - 1));
    end else begin : g_ext_timer
      assign timer_hit = 1'b0;
    end
  endgenerate

  assign done_w = wr_q && (timer_hit || mem_done);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pgm_q <= 1'b0; cfg_q <= 1'b0; er_q <= 1'b0; err_q <= 1'b0;
      wren_q <= 1'b0; wr_q <= 1'b0; rd_q <= 1'b0; start_q <= 1'b0;
      cnt_q <= '0;
    end else if (!wrst_n) begin
      if (wr_q) err_q <= 1'b1;
      wren_q  <= 1'b0;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      start_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      start_q <= 1'b0;
      rd_q    <= 1'b0;
      if (wr_q) begin
        if (done_w) begin
          wr_q  <= 1'b0;
          er_q  <= 1'b0;
          err_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        if (reg_we) wren_q <= reg_wdata[2];
      end else if (reg_we) begin
        pgm_q  <= reg_wdata[7];
        cfg_q  <= reg_wdata[6];
        er_q   <= reg_wdata[4];
        err_q  <= reg_wdata[3];
        wren_q <= reg_wdata[2];
        rd_q   <= reg_wdata[0] && !reg_wdata[7];
        if (reg_wdata[1] && wren_q) begin
          wr_q    <= 1'b1;
          start_q <= 1'b1;
          cnt_q   <= '0;
        end
      end
    end
  end

  assign reg_rdata     = {pgm_q, cfg_q, 1'b0, er_q, err_q, wren_q, wr_q, rd_q};
  assign mem_rd_stb    = rd_q;
  assign mem_wr_stb    = start_q && !er_q;
  assign mem_erase_stb = start_q && er_q;
  assign mem_sel_prog  = pgm_q;
  assign mem_sel_cfg   = cfg_q;

  a_r4_no_prog_read: assert property (@(posedge clk) disable iff (!por_n)
    mem_rd_stb |-> !reg_rdata[7]);

  a_r6_start_needs_wren: assert property (@(posedge clk) disable iff (!por_n)
    $rose(reg_rdata[1]) |-> $past(reg_rdata[2]));

  a_r5_wr_holds: assert property (@(posedge clk) disable iff (!por_n)
    (reg_rdata[1] && !done_w && wrst_n) |=> reg_rdata[1]);

  a_r12_stb_when_busy: assert property (@(posedge clk) disable iff (!por_n)
    (mem_wr_stb || mem_erase_stb) |-> reg_rdata[1]);

  a_r10_busy_write_locked: assert property (@(posedge clk) disable iff (!por_n)
    (reg_we && wrst_n && reg_rdata[1] && !done_w)
      |=> ($stable(reg_rdata[7:6]) && $stable(reg_rdata[4])));

  a_r8_abort_sets_error: assert property (@(posedge clk) disable iff (!por_n)
    (!wrst_n && reg_rdata[1]) |=> reg_rdata[3]);

  a_r8_abort_keeps_select: assert property (@(posedge clk) disable iff (!por_n)
    !wrst_n |=> ($stable(reg_rdata[7:6]) && $stable(reg_rdata[4])));
endmodule

// File: tb/test_nvm_ctl_reg.sv
module test_nvm_ctl_reg;
  localparam int CLK_PERIOD = 10;
  localparam int PC = 5;

  logic clk = 1'b0, por_n = 1'b0, wrst_n = 1'b1, reg_we = 1'b0, mem_done = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic mem_rd_stb, mem_wr_stb, mem_erase_stb, mem_sel_prog, mem_sel_cfg;
  int checks = 0, fails = 0;

  logic m_pgm, m_cfg, m_er, m_err, m_wren, m_wr, m_rd, m_start;
  int m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_ctl_reg #(.PROG_CYCLES(PC), .INT_TIMER(1'b1)) i_nvm_ctl_reg (
    .clk(clk), .por_n(por_n), .wrst_n(wrst_n), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_rd_stb(mem_rd_stb),
    .mem_wr_stb(mem_wr_stb), .mem_erase_stb(mem_erase_stb),
    .mem_sel_prog(mem_sel_prog), .mem_sel_cfg(mem_sel_cfg), .mem_done(mem_done));

  function automatic logic [7:0] exp_reg();
    return {m_pgm, m_cfg, 1'b0, m_er, m_err, m_wren, m_wr, m_rd};
  endfunction

  function automatic logic [4:0] exp_mem();
    return {m_rd, m_start && !m_er, m_start && m_er, m_pgm, m_cfg};
  endfunction

  task automatic mdl_clear();
    {m_pgm, m_cfg, m_er, m_err, m_wren, m_wr, m_rd, m_start} = '0;
    m_cnt = 0;
  endtask

  task automatic mdl_step(input logic we, input logic [7:0] d, input logic wr_n);
    logic rd_n, st_n;
    rd_n = 1'b0; st_n = 1'b0;
    if (!wr_n) begin
      if (m_wr) m_err = 1'b1;
      m_wren = 0; m_wr = 0; m_cnt = 0;
    end else if (m_wr) begin
      if (m_cnt == PC - 1) begin m_wr = 0; m_er = 0; m_err = 0; end
      else m_cnt++;
      if (we) m_wren = d[2];
    end else if (we) begin
      if (d[1] && m_wren) begin m_wr = 1; m_cnt = 0; st_n = 1; end
      rd_n = d[0] && !d[7];
      m_pgm = d[7]; m_cfg = d[6]; m_er = d[4]; m_err = d[3]; m_wren = d[2];
    end
    m_rd = rd_n; m_start = st_n;
  endtask

  task automatic compare(input string tag);
    logic [4:0] act_mem;
    act_mem = {mem_rd_stb, mem_wr_stb, mem_erase_stb, mem_sel_prog, mem_sel_cfg};
    checks++;
    if (reg_rdata !== exp_reg() || act_mem !== exp_mem()) begin
      fails++;
      $display("FAIL %s: reg=%h mem=%b expected reg=%h mem=%b",
               tag, reg_rdata, act_mem, exp_reg(), exp_mem());
    end
  endtask

  task automatic step(input logic we, input logic [7:0] d, input logic wr_n, input string tag);
    @(negedge clk);
    reg_we = we; reg_wdata = d; wrst_n = wr_n;
    @(posedge clk);
    mdl_step(we, d, wr_n);
    #(CLK_PERIOD/4);
    compare(tag);
    reg_we = 1'b0; wrst_n = 1'b1;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b1, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    mdl_clear();
    #(CLK_PERIOD * 2 + 1);
    compare("R2 power-on state");
    por_n = 1'b1;
    idle(1, "R2 after release");
    step(1, 8'hFC, 1, "R1 readback bit5 zero");
    step(1, 8'h5C, 1, "R1 readback");
    step(1, 8'h01, 1, "R3 read strobe");
    idle(1, "R3 read self-clear");
    step(1, 8'h81, 1, "R4 prog read dropped");
    step(1, 8'h02, 1, "R6 no start without enable");
    step(1, 8'h04, 1, "R6 enable set");
    step(1, 8'h06, 1, "R12 write strobe");
    step(1, 8'h04, 1, "R5 zero does not clear");
    step(1, 8'hD0, 1, "R10 busy write only enable");
    idle(PC, "R5 completion timing");
    step(1, 8'h14, 1, "R7 erase armed");
    step(1, 8'h16, 1, "R7 erase strobe");
    idle(PC, "R7 erase clears");
    step(1, 8'h94, 1, "R8 setup");
    step(1, 8'h96, 1, "R8 start");
    step(0, 8'h00, 0, "R8 warm abort error");
    idle(1, "R8 after abort");
    step(1, 8'h0C, 1, "R9 setup");
    step(1, 8'h0E, 1, "R9 start");
    idle(PC, "R9 error cleared");
    step(1, 8'hC4, 1, "R11 setup");
    step(0, 8'h00, 0, "R11 idle warm reset");
    for (int i = 0; i < 400; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      step(($urandom % 3) != 0, d, ($urandom % 25) != 0, "R1 random");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule